// File: doc/BRIEF.md
# Interrupt Flag and Collision Register

This block is a byte-wide interrupt flag register for a small processor subsystem. Six peripheral events arrive as asynchronous levels: a transfer-busy event, a one-second real-time tick, a pushbutton wake, an autowake timer expiry, and the PLL locking and unlocking. Each is synchronized and edge-detected, and its rising edge latches a sticky flag. Two more flags record collisions between a flash write engine and a periodic compute engine. One collision is a flash write requested while the engine is busy. The other is a compute pass starting while a flash write is still running.

Software clears flags by writing the whole flag byte with 0 in each bit to clear and 1 everywhere else. A written 1 never changes a flag. A second address returns the raw, unlatched levels of seven external interrupt lines, and a write there with bit 7 set restarts the watchdog. A third address holds an enable mask. The interrupt request output is high while any flag that is enabled by the mask is set.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the flag byte reads 0x00, the mask reads 0x00, irq_out is 0 and wd_restart is 0.
- R2: A 0-to-1 change on an asynchronous event input sets its flag at the third rising clock edge after the change, and not earlier. The flag bits are: ev_xfer to bit 0, ev_rtc to bit 1, ev_button to bit 4, ev_autowake to bit 5, ev_pll_up to bit 6, ev_pll_down to bit 7. An input held high does not set its flag again after the flag is cleared.
- R3: A set flag stays set through any number of cycles without a write to the flag byte (address 0).
- R4: A write to address 0 clears each flag whose write-data bit is 0 and leaves each flag whose write-data bit is 1 unchanged. A write of 0xFF changes no flag.
- R5: If a flag's set event and a clearing write hit the same clock edge, the flag ends up set.
- R6: flash_wr_req high while ce_busy is high sets flag bit 2 at that clock edge. flash_wr_req while ce_busy is low does not set it.
- R7: ce_pass_start high while flash_wr_busy is high sets flag bit 3 at that clock edge. ce_pass_start while flash_wr_busy is low does not set it.
- R8: A read of address 1 returns ext_irq_lines in bits 6:0, combinationally and with no storage. Bit 7 reads 0.
- R9: A write to address 1 with data bit 7 set makes wd_restart high for exactly the one cycle after that edge. Such a write with bit 7 clear produces no pulse.
- R10: Address 2 is a read/write enable mask. irq_out is high exactly when (flags AND mask) is nonzero.
- R11: Address 3 reads 0x00, and writes to it change no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address (0 flags, 1 lines/watchdog, 2 mask, 3 unused) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable, one write per cycle |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ev_xfer | input | 1 | Transfer-busy event level, asynchronous |
| ev_rtc | input | 1 | One-second tick level, asynchronous |
| ev_button | input | 1 | Pushbutton wake level, asynchronous |
| ev_autowake | input | 1 | Autowake timer level, asynchronous |
| ev_pll_up | input | 1 | PLL lock-gained level, asynchronous |
| ev_pll_down | input | 1 | PLL lock-lost level, asynchronous |
| flash_wr_req | input | 1 | One-cycle flash write request, synchronous |
| flash_wr_busy | input | 1 | Flash write in progress, synchronous |
| ce_busy | input | 1 | Compute engine busy, synchronous |
| ce_pass_start | input | 1 | One-cycle compute pass start, synchronous |
| ext_irq_lines | input | 7 | External interrupt line levels |
| wd_restart | output | 1 | One-cycle watchdog restart pulse |
| irq_out | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
Directed cases raise each asynchronous event alone and check its flag after two and after three edges. This confirms both the bit placement and the synchronizer latency, and it shows that a held level does not retrigger. Write patterns that clear one bit, clear none (0xFF) and collide with a set event show whether the design treats written 1s as "keep" and whether a set wins over a clear. A constrained-random phase mixes flag writes, mask writes, watchdog writes, writes to the unused address, and collision inputs with and without the engine busy signals. It compares read data, irq_out and wd_restart every cycle against a reference model in the bench. This covers the collision gating and the mask interaction under many combinations.

// File: rtl/irqf_pkg.sv
// Package: shared constants for the interrupt flag unit.
// Assumes an 8-bit register bus and the fixed flag bit layout below.
package irqf_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_ASYNC  = 6;

    // Flag bit positions (software decodes these)
    localparam int FB_XFER    = 0;
    localparam int FB_RTC     = 1;
    localparam int FB_COL0    = 2;
    localparam int FB_COL1    = 3;
    localparam int FB_BUTTON  = 4;
    localparam int FB_WAKE    = 5;
    localparam int FB_PLLUP   = 6;
    localparam int FB_PLLDN   = 7;

    // Register addresses
    localparam int ADR_FLAGS  = 0;
    localparam int ADR_LINES  = 1;
    localparam int ADR_MASK   = 2;

    // Bit position of the watchdog restart command in the lines register
    localparam int WD_BIT     = 7;

    // Maps asynchronous event index to its flag bit
    function automatic int async_flag_bit(input int idx);
        case (idx)
            0:       return FB_XFER;
            1:       return FB_RTC;
            2:       return FB_BUTTON;
            3:       return FB_WAKE;
            4:       return FB_PLLUP;
            default: return FB_PLLDN;
        endcase
    endfunction
endpackage

// File: rtl/irqf_edge_sync.sv
// Module: irqf_edge_sync
// Brings one asynchronous level into the clock domain through STAGES
// flops, then emits a one-cycle pulse on its rising edge.
// Assumes STAGES >= 2 and inputs that stay stable for at least two cycles.
module irqf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], async_in};
    end

    // Rising edge of the synchronized level
    assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];

    // R2: an edge produces exactly one pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse)
        else $error("a_r2_single_pulse");
endmodule

// File: rtl/irqf_collide.sv
// Module: irqf_collide
// Detects the two flash/compute-engine collisions in the current cycle.
// Assumes all four inputs are synchronous to the register clock.
module irqf_collide (
    input  logic       flash_wr_req,
    input  logic       flash_wr_busy,
    input  logic       ce_busy,
    input  logic       ce_pass_start,
    output logic [1:0] col_hit
);
    // Bit 0: write requested into a busy engine; bit 1: pass starts mid-write
    always_comb begin
        col_hit[0] = flash_wr_req  & ce_busy;
        col_hit[1] = ce_pass_start & flash_wr_busy;
    end
endmodule

// File: rtl/irqf_flag_bank.sv
// Module: irqf_flag_bank
// Sticky flag register. Hardware sets, software clears by writing 0s.
// A written 1 keeps the flag. A set in the same cycle as a clear wins.
module irqf_flag_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] keep_mask;

    // Bits to keep: all of them unless a write names them with 0
    always_comb keep_mask = clr_we ? clr_data : '1;

    // Flag update: clear first, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & keep_mask) | set_vec;
    end

    // R5: any set event is visible after the edge, whatever was written
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)))
        else $error("a_r5_set_wins");

    // R3: without a write no flag drops
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)))
        else $error("a_r3_hold");

    // R4: a set flag written with 1 stays set
    a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(flags & clr_data)) == $past(flags & clr_data)))
        else $error("a_r4_one_keeps");
endmodule

// File: rtl/irq_flag_unit.sv
// Module: irq_flag_unit (top)
// Interrupt flag byte, live interrupt-line byte with watchdog restart,
// and interrupt enable mask on a simple register bus.
// Assumes one bus access per cycle and combinational reads.
module irq_flag_unit
    import irqf_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int NUM_EXT     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_we,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               ev_xfer,
    input  logic               ev_rtc,
    input  logic               ev_button,
    input  logic               ev_autowake,
    input  logic               ev_pll_up,
    input  logic               ev_pll_down,
    input  logic               flash_wr_req,
    input  logic               flash_wr_busy,
    input  logic               ce_busy,
    input  logic               ce_pass_start,
    input  logic [NUM_EXT-1:0] ext_irq_lines,
    output logic               wd_restart,
    output logic               irq_out
);
    localparam int PAD_W = DATA_W - NUM_EXT;

    logic [NUM_ASYNC-1:0] ev_level;
    logic [NUM_ASYNC-1:0] ev_pulse;
    logic [1:0]           col_hit;
    logic [DATA_W-1:0]    set_vec;
    logic [DATA_W-1:0]    irq_flags;
    logic [DATA_W-1:0]    irq_mask;
    logic                 wr_flags;
    logic                 wr_lines;
    logic                 wr_mask;

    // Event levels in async index order
    assign ev_level = {ev_pll_down, ev_pll_up, ev_autowake,
                       ev_button, ev_rtc, ev_xfer};

    // One synchronizer and edge detector per asynchronous event
    for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
        irqf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .async_in  (ev_level[g]),
            .rise_pulse(ev_pulse[g])
        );
    end

    irqf_collide u_collide (
        .flash_wr_req (flash_wr_req),
        .flash_wr_busy(flash_wr_busy),
        .ce_busy      (ce_busy),
        .ce_pass_start(ce_pass_start),
        .col_hit      (col_hit)
    );

    // Assemble per-bit set requests in flag layout
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_ASYNC; i++)
            set_vec[async_flag_bit(i)] = ev_pulse[i];
        set_vec[FB_COL0] = col_hit[0];
        set_vec[FB_COL1] = col_hit[1];
    end

    // Write decode
    always_comb begin
        wr_flags = reg_we && (reg_addr == ADDR_W'(ADR_FLAGS));
        wr_lines = reg_we && (reg_addr == ADDR_W'(ADR_LINES));
        wr_mask  = reg_we && (reg_addr == ADDR_W'(ADR_MASK));
    end

    irqf_flag_bank #(.WIDTH(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_we  (wr_flags),
        .clr_data(reg_wdata),
        .flags   (irq_flags)
    );

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_mask <= '0;
        else if (wr_mask) irq_mask <= reg_wdata;
    end

    // Watchdog restart: one-cycle pulse after a qualifying write
    always_ff @(posedge clk) begin
        if (!rst_n) wd_restart <= 1'b0;
        else        wd_restart <= wr_lines & reg_wdata[WD_BIT];
    end

    // Read mux; the lines byte is unregistered
    always_comb begin
        case (reg_addr)
            ADDR_W'(ADR_FLAGS): reg_rdata = irq_flags;
            ADDR_W'(ADR_LINES): reg_rdata = {{PAD_W{1'b0}}, ext_irq_lines};
            ADDR_W'(ADR_MASK):  reg_rdata = irq_mask;
            default:            reg_rdata = '0;
        endcase
    end

    // Interrupt request from enabled flags
    assign irq_out = |(irq_flags & irq_mask);

    // R6: write into busy engine records collision 0
    a_r6_col0: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_wr_req && ce_busy) |=> irq_flags[FB_COL0])
        else $error("a_r6_col0");

    // R7: pass start during flash write records collision 1
    a_r7_col1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pass_start && flash_wr_busy) |=> irq_flags[FB_COL1])
        else $error("a_r7_col1");

    // R9: a restart pulse always traces back to a qualifying write
    a_r9_kick_source: assert property (@(posedge clk) disable iff (!rst_n)
        wd_restart |-> $past(reg_we && reg_addr == ADDR_W'(ADR_LINES) && reg_wdata[WD_BIT]))
        else $error("a_r9_kick_source");

    // R10: a zero mask keeps the request low
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq_out)
        else $error("a_r10_masked_quiet");
endmodule

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic       reg_we = 0;
    logic [7:0] reg_rdata;
    logic       ev_xfer = 0, ev_rtc = 0, ev_button = 0, ev_autowake = 0;
    logic       ev_pll_up = 0, ev_pll_down = 0;
    logic       flash_wr_req = 0, flash_wr_busy = 0, ce_busy = 0, ce_pass_start = 0;
    logic [6:0] ext_irq_lines = 0;
    logic       wd_restart, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_flag_unit dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ev(input int idx, input logic v);
        case (idx)
            0: ev_xfer = v;     1: ev_rtc = v;      2: ev_button = v;
            3: ev_autowake = v; 4: ev_pll_up = v;   default: ev_pll_down = v;
        endcase
    endtask

    function automatic logic [7:0] ev_bit(input int idx);
        case (idx)
            0: return 8'h01; 1: return 8'h02; 2: return 8'h10;
            3: return 8'h20; 4: return 8'h40; default: return 8'h80;
        endcase
    endfunction

    // Single write at the next edge, bus idle afterwards
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_we = 0; #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] f, input logic we_f,
                                              input logic [7:0] d, input logic [7:0] set);
        return (f & (we_f ? d : 8'hFF)) | set;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, ef, em;
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd(0, d); chk("R1 flags", d, 8'h00);
        rd(2, d); chk("R1 mask", d, 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);
        chk("R1 wd", {7'b0, wd_restart}, 8'h00);

        // R2 each async event: latency and bit position
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); reg_addr = 0; set_ev(i, 1);
            @(posedge clk); @(posedge clk); #1;
            chk("R2 not yet after two edges", reg_rdata, 8'h00);
            @(posedge clk); #1;
            chk("R2 event bit", reg_rdata, ev_bit(i));
            // R3 held for many cycles
            repeat (10) @(posedge clk); #1;
            chk("R3 hold", reg_rdata, ev_bit(i));
            // R4 0xFF write keeps
            wr(0, 8'hFF); rd(0, d); chk("R4 ones keep", d, ev_bit(i));
            // R4 clear; R2 held level no retrigger
            wr(0, ~ev_bit(i)); repeat (4) @(posedge clk);
            rd(0, d); chk("R2 no retrigger / R4 clear", d, 8'h00);
            @(negedge clk); set_ev(i, 0);
            repeat (4) @(posedge clk);
        end

        // R5 set and clear in the same edge
        @(negedge clk); ev_rtc = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_addr = 0; reg_wdata = 8'h00; reg_we = 1;
        @(negedge clk); reg_we = 0; #1;
        chk("R5 set wins", reg_rdata, 8'h02);
        @(negedge clk); ev_rtc = 0;
        wr(0, 8'h00); rd(0, d); chk("R4 clear all", d, 8'h00);

        // R6 / R7 gated collisions
        @(negedge clk); flash_wr_req = 1; ce_busy = 0;
        @(negedge clk); flash_wr_req = 0; #1; chk("R6 no busy no flag", reg_rdata, 8'h00);
        @(negedge clk); flash_wr_req = 1; ce_busy = 1;
        @(negedge clk); flash_wr_req = 0; ce_busy = 0; #1; chk("R6 collision 0", reg_rdata, 8'h04);
        @(negedge clk); ce_pass_start = 1; flash_wr_busy = 0;
        @(negedge clk); ce_pass_start = 0; #1; chk("R7 no busy no flag", reg_rdata, 8'h04);
        @(negedge clk); ce_pass_start = 1; flash_wr_busy = 1;
        @(negedge clk); ce_pass_start = 0; flash_wr_busy = 0; #1; chk("R7 collision 1", reg_rdata, 8'h0C);
        wr(0, 8'hFB); rd(0, d); chk("R4 single clear", d, 8'h08);

        // R10 mask and irq
        chk("R10 irq unmasked", {7'b0, irq_out}, 8'h00);
        wr(2, 8'h08); rd(2, d); chk("R10 mask readback", d, 8'h08);
        chk("R10 irq on", {7'b0, irq_out}, 8'h01);
        wr(2, 8'hF7); chk("R10 irq off other bits", {7'b0, irq_out}, 8'h00);

        // R11 unused address
        wr(3, 8'h00); rd(3, d); chk("R11 reads zero", d, 8'h00);
        rd(0, d); chk("R11 flags untouched", d, 8'h08);
        rd(2, d); chk("R11 mask untouched", d, 8'hF7);

        // R8 live lines
        ext_irq_lines = 7'h55; rd(1, d); chk("R8 lines", d, 8'h55);
        ext_irq_lines = 7'h7F; #1; chk("R8 lines live bit7 zero", reg_rdata, 8'h7F);

        // R9 watchdog pulse
        @(negedge clk); reg_addr = 1; reg_wdata = 8'h80; reg_we = 1;
        @(negedge clk); reg_we = 0; chk("R9 pulse", {7'b0, wd_restart}, 8'h01);
        @(negedge clk); chk("R9 one cycle", {7'b0, wd_restart}, 8'h00);
        @(negedge clk); reg_wdata = 8'h7F; reg_we = 1;
        @(negedge clk); reg_we = 0; chk("R9 no pulse bit7 clear", {7'b0, wd_restart}, 8'h00);

        // Random phase, model checked every cycle
        wr(0, 8'h00); wr(2, 8'h00);
        ef = 8'h00; em = 8'h00;
        begin
            logic exp_wd = 0;
            for (int n = 0; n < 3000; n++) begin
                logic [7:0] set;
                logic       wf;
                @(negedge clk);
                chk("R10 irq model", {7'b0, irq_out}, {7'b0, |(ef & em)});
                chk("R9 wd model", {7'b0, wd_restart}, {7'b0, exp_wd});
                reg_addr      = 2'($urandom_range(0, 3));
                reg_we        = 1'($urandom);
                reg_wdata     = 8'($urandom);
                flash_wr_req  = ($urandom_range(0, 3) == 0);
                ce_busy       = 1'($urandom);
                ce_pass_start = ($urandom_range(0, 3) == 0);
                flash_wr_busy = 1'($urandom);
                ext_irq_lines = 7'($urandom);
                #1;
                if (!reg_we) begin
                    case (reg_addr)
                        0: chk("R4/R6/R7 flags model", reg_rdata, ef);
                        1: chk("R8 lines model", reg_rdata, {1'b0, ext_irq_lines});
                        2: chk("R10 mask model", reg_rdata, em);
                        default: chk("R11 model", reg_rdata, 8'h00);
                    endcase
                end
                set = {4'b0, ce_pass_start & flash_wr_busy, flash_wr_req & ce_busy, 2'b0};
                wf = reg_we && reg_addr == 0;
                ef = model_next(ef, wf, reg_wdata, set);
                if (reg_we && reg_addr == 2) em = reg_wdata;
                exp_wd = reg_we && reg_addr == 1 && reg_wdata[7];
            end
        end
        @(negedge clk); reg_we = 0; flash_wr_req = 0; ce_pass_start = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule